// File: doc/BRIEF.md
# Dual Interval Timer with Reload Latch

This block holds two 16-bit down-counters behind a byte-wide register window. The first counter owns a full 16-bit reload latch. It runs from the latch value down through 0xFFFF and then reloads, so one period lasts latch + 2 ticks. When the auxiliary control byte selects continuous operation, the block emits an event pulse each time this counter arrives at zero. The second counter is a one-shot. It is loaded from a written high byte joined to a stored low byte. It keeps decrementing and wrapping after the load, but it reports its arrival at zero only once per load.

Both counters advance only on cycles where the tick enable input is high. A bus master reads and writes the timers through a 4-bit register index. Some of those accesses also have side effects: they reload a counter or ask the flag controller to clear a timer flag. The flag controller sits outside this block. It takes the event pulses and the clear strobes that this block produces.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, the first counter and its latch read 0xFFFF, the second counter reads 0xFFFF, its low latch reads 0x00, the auxiliary byte reads 0x00, and no event is pending.
- R2: On each tick, the first counter decrements by one. Instead, from 0xFFFF it reloads the latch value, giving a period of latch + 2 ticks. With tick enable low, neither counter moves.
- R3: When aux_ctrl[7:6] = 2'b01, t1_evt pulses for one cycle in the cycle where the first counter has just become zero through a tick. With any other mode it stays low.
- R4: A write to index 5 puts the byte in the latch high half and loads the counter with the whole new latch.
- R5: A write to index 4 or index 6 changes only the latch low half. The counter keeps its value or its normal tick.
- R6: A write to index 7 changes the latch high half and does not reload the counter.
- R7: t1_clr is high during a write to index 5 or 7 and during a read of index 4. t2_clr is high during a read of index 8. No other access raises either strobe.
- R8: A write to index 8 stores the byte as the second timer's low latch and loads the counter with {0x00, byte}. A write to index 9 loads the counter with {byte, low latch}.
- R9: The second counter decrements by one per tick and wraps from 0x0000 to 0xFFFF. t2_evt pulses once, the first time a tick brings it to zero after a load, and not again until the next load.
- R10: rd_data returns the selected byte with no delay. Index 4/5 give the first counter low/high, 6/7 give the latch low/high, 8/9 give the second counter low/high, 11 gives the auxiliary byte, and every other index gives 0x00.
- R11: A load by a counter write in a tick cycle takes precedence: that counter takes the loaded value and skips the decrement.
- R12: A write to index 11 stores the auxiliary control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advances both counters by one step |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe, used only for the read side effects |
| reg_sel | input | 4 | Register index |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Selected register byte |
| t1_count | output | 16 | First counter value |
| t1_latch | output | 16 | First timer reload latch |
| t2_count | output | 16 | Second counter value |
| t2_latch_lo | output | 8 | Second timer stored low byte |
| aux_ctrl | output | 8 | Auxiliary control byte |
| t1_evt | output | 1 | First timer zero event pulse |
| t2_evt | output | 1 | Second timer one-shot event pulse |
| t1_clr | output | 1 | Clear request for the first timer flag |
| t2_clr | output | 1 | Clear request for the second timer flag |

## Verification
The properties treat reg_sel, wr_en and tick_en as clean, sampled values at every edge. They also treat a write as one access in one cycle. The stepping property for the first counter is guarded so that it applies only when no index 5 load competes with the tick. The stimulus changes inputs only on the falling edge, which keeps it within these assumptions. It also keeps exactly one index per cycle, and it randomises tick, write and read activity only over valid indices.

// File: rtl/dual_interval_timer.sv
module dual_interval_timer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  reg_sel,
  input  logic [7:0]  wr_data,
  output logic [7:0]  rd_data,
  output logic [15:0] t1_count,
  output logic [15:0] t1_latch,
  output logic [15:0] t2_count,
  output logic [7:0]  t2_latch_lo,
  output logic [7:0]  aux_ctrl,
  output logic        t1_evt,
  output logic        t2_evt,
  output logic        t1_clr,
  output logic        t2_clr
);
  localparam logic [3:0] IX_T1C_LO = 4'd4;
  localparam logic [3:0] IX_T1C_HI = 4'd5;
  localparam logic [3:0] IX_T1L_LO = 4'd6;
  localparam logic [3:0] IX_T1L_HI = 4'd7;
  localparam logic [3:0] IX_T2_LO  = 4'd8;
  localparam logic [3:0] IX_T2_HI  = 4'd9;
  localparam logic [3:0] IX_AUX    = 4'd11;
  localparam logic [1:0] MODE_CONT = 2'b01;

  logic        t2_armed;
  logic [15:0] t1_next, t2_next;

  wire w_lo1  = wr_en && (reg_sel == IX_T1C_LO || reg_sel == IX_T1L_LO);
  wire w_ld1  = wr_en && reg_sel == IX_T1C_HI;
  wire w_hi1  = wr_en && reg_sel == IX_T1L_HI;
  wire w_lo2  = wr_en && reg_sel == IX_T2_LO;
  wire w_hi2  = wr_en && reg_sel == IX_T2_HI;
  wire w_aux  = wr_en && reg_sel == IX_AUX;
  wire cont1  = aux_ctrl[7:6] == MODE_CONT;

  assign t1_next = (t1_count == 16'hFFFF) ? t1_latch : t1_count - 16'd1;
  assign t2_next = t2_count - 16'd1;

  assign t1_clr = w_ld1 || w_hi1 || (rd_en && reg_sel == IX_T1C_LO);
  assign t2_clr = rd_en && reg_sel == IX_T2_LO;

  always_comb begin
    case (reg_sel)
      IX_T1C_LO: rd_data = t1_count[7:0];
      IX_T1C_HI: rd_data = t1_count[15:8];
      IX_T1L_LO: rd_data = t1_latch[7:0];
      IX_T1L_HI: rd_data = t1_latch[15:8];
      IX_T2_LO:  rd_data = t2_count[7:0];
      IX_T2_HI:  rd_data = t2_count[15:8];
      IX_AUX:    rd_data = aux_ctrl;
      default:   rd_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t1_count    <= 16'hFFFF;
      t1_latch    <= 16'hFFFF;
      t2_count    <= 16'hFFFF;
      t2_latch_lo <= 8'h00;
      aux_ctrl    <= 8'h00;
      t2_armed    <= 1'b0;
      t1_evt      <= 1'b0;
      t2_evt      <= 1'b0;
    end else begin
      t1_evt <= 1'b0;
      t2_evt <= 1'b0;

      if (w_lo1) t1_latch[7:0] <= wr_data;
      if (w_ld1 || w_hi1) t1_latch[15:8] <= wr_data;

      if (w_ld1) begin
        t1_count <= {wr_data, t1_latch[7:0]};
      end else if (tick_en) begin
        t1_count <= t1_next;
        t1_evt   <= cont1 && t1_next == 16'h0000;
      end

      if (w_lo2) begin
        t2_latch_lo <= wr_data;
        t2_count    <= {8'h00, wr_data};
        t2_armed    <= 1'b1;
      end else if (w_hi2) begin
        t2_count <= {wr_data, t2_latch_lo};
        t2_armed <= 1'b1;
      end else if (tick_en) begin
        t2_count <= t2_next;
        if (t2_armed && t2_next == 16'h0000) begin
          t2_evt   <= 1'b1;
          t2_armed <= 1'b0;
        end
      end

      if (w_aux) aux_ctrl <= wr_data;
    end
  end
endmodule

// File: rtl/dual_interval_timer_chk.sv
module dual_interval_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        wr_en,
  input logic [3:0]  reg_sel,
  input logic [15:0] t1_count,
  input logic [15:0] t1_latch,
  input logic [15:0] t2_count,
  input logic [7:0]  aux_ctrl,
  input logic        t1_evt,
  input logic        t2_evt
);
  // R3
  t1_evt_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t1_evt |-> t1_count == 16'h0000);

  // R3
  t1_evt_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t1_evt |-> $past(aux_ctrl[7:6]) == 2'b01);

  // R9
  t2_evt_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t2_evt |-> t2_count == 16'h0000);

  // R4
  t1_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 4'd5) |=> t1_count == t1_latch);

  // R2
  t1_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !(wr_en && reg_sel == 4'd5) && t1_count != 16'hFFFF)
      |=> t1_count == $past(t1_count) - 16'd1);

  // R6
  t1_latch_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && wr_en && reg_sel == 4'd7) |=> $stable(t1_count));

  // R9
  t2_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t2_evt |=> !t2_evt);
endmodule

bind dual_interval_timer dual_interval_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
  .reg_sel(reg_sel), .t1_count(t1_count), .t1_latch(t1_latch),
  .t2_count(t2_count), .aux_ctrl(aux_ctrl), .t1_evt(t1_evt), .t2_evt(t2_evt)
);

// File: tb/dual_interval_timer_tb_top.sv
`timescale 1ns/1ps
module dual_interval_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] reg_sel = 4'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data, t2_latch_lo, aux_ctrl;
  logic [15:0] t1_count, t1_latch, t2_count;
  logic t1_evt, t2_evt, t1_clr, t2_clr;

  int tests = 0, fails = 0, ev1 = 0, ev2 = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_c1, m_l1, m_c2;
  logic [7:0]  m_l2, m_acr;
  logic        m_arm, m_e1, m_e2;

  always #2.5 clk = ~clk;

  dual_interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
    .t1_count(t1_count), .t1_latch(t1_latch), .t2_count(t2_count),
    .t2_latch_lo(t2_latch_lo), .aux_ctrl(aux_ctrl), .t1_evt(t1_evt),
    .t2_evt(t2_evt), .t1_clr(t1_clr), .t2_clr(t2_clr));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_c1 = 16'hFFFF; m_l1 = 16'hFFFF; m_c2 = 16'hFFFF;
      m_l2 = 8'h00; m_acr = 8'h00; m_arm = 0; m_e1 = 0; m_e2 = 0;
    end else begin
      m_e1 = 0; m_e2 = 0;
      if (wr_en && reg_sel == 4'd5) begin
        m_l1[15:8] = wr_data;
        m_c1 = m_l1;
      end else if (tick_en) begin
        if (m_c1 == 16'hFFFF) m_c1 = m_l1;
        else m_c1 = m_c1 - 16'd1;
        m_e1 = (m_acr[7:6] == 2'b01) && (m_c1 == 16'h0000);
      end
      if (wr_en && (reg_sel == 4'd4 || reg_sel == 4'd6)) m_l1[7:0] = wr_data;
      if (wr_en && reg_sel == 4'd7) m_l1[15:8] = wr_data;
      if (wr_en && reg_sel == 4'd8) begin
        m_l2 = wr_data; m_c2 = {8'h00, wr_data}; m_arm = 1;
      end else if (wr_en && reg_sel == 4'd9) begin
        m_c2 = {wr_data, m_l2}; m_arm = 1;
      end else if (tick_en) begin
        m_c2 = m_c2 - 16'd1;
        if (m_arm && m_c2 == 16'h0000) begin m_e2 = 1; m_arm = 0; end
      end
      if (wr_en && reg_sel == 4'd11) m_acr = wr_data;
    end
  end

  task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_rd(input logic [3:0] s);
    case (s)
      4'd4: return m_c1[7:0];
      4'd5: return m_c1[15:8];
      4'd6: return m_l1[7:0];
      4'd7: return m_l1[15:8];
      4'd8: return m_c2[7:0];
      4'd9: return m_c2[15:8];
      4'd11: return m_acr;
      default: return 8'h00;
    endcase
  endfunction

  task automatic cmp_regs();
    chk("R2 t1_count", t1_count === m_c1, t1_count, m_c1);
    chk("R4 t1_latch", t1_latch === m_l1, t1_latch, m_l1);
    chk("R9 t2_count", t2_count === m_c2, t2_count, m_c2);
    chk("R8 t2_latch_lo", t2_latch_lo === m_l2, t2_latch_lo, m_l2);
    chk("R12 aux_ctrl", aux_ctrl === m_acr, aux_ctrl, m_acr);
    chk("R3 t1_evt", t1_evt === m_e1, t1_evt, m_e1);
    chk("R9 t2_evt", t2_evt === m_e2, t2_evt, m_e2);
    if (t1_evt === 1'b1) ev1++;
    if (t2_evt === 1'b1) ev2++;
  endtask

  task automatic step(input bit tk, input bit wr, input bit rd, input logic [3:0] s, input logic [7:0] d);
    logic c1, c2;
    @(negedge clk);
    cmp_regs();
    tick_en = tk; wr_en = wr; rd_en = rd; reg_sel = s; wr_data = d;
    #1;
    c1 = (wr && (s == 4'd5 || s == 4'd7)) || (rd && s == 4'd4);
    c2 = rd && s == 4'd8;
    chk("R10 rd_data", rd_data === m_rd(s), rd_data, m_rd(s));
    chk("R7 t1_clr", t1_clr === c1, t1_clr, c1);
    chk("R7 t2_clr", t2_clr === c2, t2_clr, c2);
  endtask

  task automatic peek();
    @(posedge clk); #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 4'd0, 8'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    peek();
    // R1 reset state
    chk("R1 t1_count", t1_count === 16'hFFFF, t1_count, 16'hFFFF);
    chk("R1 t1_latch", t1_latch === 16'hFFFF, t1_latch, 16'hFFFF);
    chk("R1 t2_count", t2_count === 16'hFFFF, t2_count, 16'hFFFF);
    chk("R1 t2_latch_lo", t2_latch_lo === 8'h00, t2_latch_lo, 0);
    chk("R1 evts", {t1_evt, t2_evt} === 2'b00, {t1_evt, t2_evt}, 0);

    // R12 continuous mode, R4 load of 3
    step(0, 1, 0, 4'd11, 8'h40);
    step(0, 1, 0, 4'd4, 8'h03);
    step(0, 1, 0, 4'd5, 8'h00);
    peek();
    chk("R4 load", t1_count === 16'h0003, t1_count, 16'h0003);
    // R2/R3: period 5, 15 ticks -> 3 events
    ev1 = 0;
    ticks(15);
    step(0, 0, 0, 4'd0, 8'd0);
    chk("R3 events continuous", ev1 == 3, ev1, 3);
    // R3 other mode: no events
    step(0, 1, 0, 4'd11, 8'h00);
    ev1 = 0;
    ticks(12);
    step(0, 0, 0, 4'd0, 8'd0);
    chk("R3 no events", ev1 == 0, ev1, 0);
    // R2 no tick: counter holds
    begin
      logic [15:0] held;
      step(0, 0, 0, 4'd0, 8'd0);
      peek(); held = t1_count;
      step(0, 0, 0, 4'd0, 8'd0); step(0, 0, 0, 4'd0, 8'd0);
      peek();
      chk("R2 hold", t1_count === held, t1_count, held);
      // R5 latch low write leaves counter
      step(0, 1, 0, 4'd6, 8'h09);
      peek();
      chk("R5 counter kept", t1_count === held, t1_count, held);
      chk("R5 latch lo", t1_latch[7:0] === 8'h09, t1_latch[7:0], 8'h09);
      // R6 latch high write, no reload
      step(0, 1, 0, 4'd7, 8'h01);
      peek();
      chk("R6 counter kept", t1_count === held, t1_count, held);
      chk("R6 latch", t1_latch === 16'h0109, t1_latch, 16'h0109);
    end
    // R11 load during tick
    step(1, 1, 0, 4'd5, 8'h00);
    peek();
    chk("R11 load wins", t1_count === 16'h0009, t1_count, 16'h0009);
    // R7 reads
    step(0, 0, 1, 4'd4, 8'd0);
    step(0, 0, 1, 4'd8, 8'd0);
    step(0, 0, 1, 4'd9, 8'd0);
    step(0, 0, 1, 4'd6, 8'd0);
    // R8 timer 2 loads
    step(0, 1, 0, 4'd8, 8'h05);
    peek();
    chk("R8 low load", t2_count === 16'h0005, t2_count, 16'h0005);
    step(0, 1, 0, 4'd9, 8'h01);
    peek();
    chk("R8 high load", t2_count === 16'h0105, t2_count, 16'h0105);
    // R9 one-shot
    step(0, 1, 0, 4'd8, 8'h04);
    ev2 = 0;
    ticks(10);
    step(0, 0, 0, 4'd0, 8'd0);
    chk("R9 one event", ev2 == 1, ev2, 1);
    ev2 = 0;
    ticks(10);
    step(0, 0, 0, 4'd0, 8'd0);
    chk("R9 no repeat", ev2 == 0, ev2, 0);
    // R9 wrap from load of zero
    step(0, 1, 0, 4'd8, 8'h00);
    ev2 = 0;
    ticks(65537);
    step(0, 0, 0, 4'd0, 8'd0);
    chk("R9 wrap event", ev2 == 1, ev2, 1);
    // R10 every index
    for (int s = 0; s < 16; s++) step(0, 0, 0, s[3:0], 8'd0);
    // mixed traffic
    step(0, 1, 0, 4'd11, 8'h40);
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] s;
      s = 4'($urandom_range(4, 11));
      step(($urandom % 4) != 0, ($urandom % 8) == 0, ($urandom % 6) == 0,
           s, (s == 4'd5 || s == 4'd9) ? 8'h00 : 8'($urandom % 12));
    end
    step(0, 0, 0, 4'd0, 8'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule